// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block takes a six-byte slice of instruction memory, beginning at the current program counter, and splits the first instruction in it into fields. The fields are an instruction code, a function code, two register identifiers and a 32-bit constant. It also reports the instruction's length in bytes and the address of the following instruction. It flags opcodes outside the supported subset, and it flags halt. The supported subset is halt, nop, register-to-register move, immediate-to-register move, register-to-memory store, memory-to-register load, and four arithmetic/logic operations: add, subtract, and, xor.

The instruction length and the positions of all fields follow from the first byte alone. Byte 0 of the slice lies in bits [7:0] of `win_bytes`, byte 1 in bits [15:8], and so on. The register identifier 0xF stands for "no register". Constants are rebuilt from four bytes in little-endian order.

There is one pipeline register between the slice and the decoded fields, so results appear one cycle after the inputs. The block has no sequencing states. Its only state is the output register, with two conditions:

- **reset-idle**: the register holds the reset pattern.
- **decoded**: the register holds the decode of the previous cycle's inputs.

It moves from reset-idle to decoded on the first clock edge after reset is released. It stays in decoded on every edge after that.

Top module: `insn_len_decoder`

## Requirements
- R1: While reset is asserted (`rst_n` low), the outputs are: codes 0, both register fields 0xF, constant 0, length 0, next address 0, invalid flag 0, halt flag 0.
- R2: Each output reflects the `pc_in`/`win_bytes` values that were present at the previous rising clock edge. `op_code` is bits [7:4] of byte 0 and `fn_code` is bits [3:0] of byte 0, for every byte value, valid or not.
- R3: The length output `insn_len` is 1 for halt (0x00), nop (0x10) and any invalid instruction. It is 2 for register move (0x20) and for arithmetic (0x6f, f = 0..3). It is 6 for immediate move (0x30), store (0x40) and load (0x50).
- R4: For 0x20, 0x4x, 0x5x and 0x6x, `reg_a` is bits [7:4] of byte 1 and `reg_b` is bits [3:0] of byte 1. For immediate move, `reg_a` is 0xF whatever byte 1 holds, and `reg_b` is bits [3:0] of byte 1.
- R5: For immediate move, store and load, `imm_val` equals byte2 + byte3·2^8 + byte4·2^16 + byte5·2^24. Example: the bytes 30 82 cd ab 00 00 give `imm_val` 0x0000abcd and `reg_b` 2. For every other instruction, `imm_val` is 0.
- R6: For halt, nop and invalid instructions, both register fields are 0xF.
- R7: `next_pc` equals the registered `pc_in` plus `insn_len`, modulo 2^32. This includes wraparound past 0xFFFFFFFF.
- R8: Arithmetic with function codes 0..3 is valid. Function codes 4..15 with instruction code 6 are invalid.
- R9: `bad_insn` is 1 in these cases: an instruction code of 7..15; a nonzero function code with instruction codes 0..5; a function code above 3 with instruction code 6. Otherwise it is 0.
- R10: `halt_seen` is 1 exactly when byte 0 is 0x00. It is never 1 together with `bad_insn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_in | input | 32 | Address of byte 0 of the slice |
| win_bytes | input | 48 | Six instruction bytes, byte 0 in bits [7:0] |
| op_code | output | 4 | Instruction code (upper nibble of byte 0) |
| fn_code | output | 4 | Function code (lower nibble of byte 0) |
| reg_a | output | 4 | First register ID, 0xF if unused |
| reg_b | output | 4 | Second register ID, 0xF if unused |
| imm_val | output | 32 | Constant or displacement, 0 if unused |
| insn_len | output | 3 | Instruction length in bytes |
| next_pc | output | 32 | Address of the following instruction |
| bad_insn | output | 1 | Invalid instruction flag |
| halt_seen | output | 1 | Halt instruction flag |

## Verification
The only internal state is the output register. A wrong entry in it therefore shows at the ports in the very cycle after the stimulus: a length other than 1, 2 or 6, a next address that does not advance by the length, or a register field that is not 0xF next to a raised invalid flag. The first-byte sweep covers all 256 values, and the second-byte sweep covers all 256 values for both a register-pair form and the immediate form. As a result, a misclassified opcode, a swapped nibble or a misordered constant byte appears within one cycle of the pattern that exposes it.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

    localparam int WIN_BYTES   = 6;
    localparam int WIN_W       = WIN_BYTES * 8;
    localparam int IMM_BYTES   = 4;
    localparam int IMM_W       = IMM_BYTES * 8;
    localparam int IMM_FIRST   = 2;
    localparam int LEN_W       = 3;

    localparam logic [3:0] REG_NONE  = 4'hF;

    localparam logic [3:0] OPC_HALT  = 4'h0;
    localparam logic [3:0] OPC_NOP   = 4'h1;
    localparam logic [3:0] OPC_RMOVE = 4'h2;
    localparam logic [3:0] OPC_IMOVE = 4'h3;
    localparam logic [3:0] OPC_STORE = 4'h4;
    localparam logic [3:0] OPC_LOAD  = 4'h5;
    localparam logic [3:0] OPC_ALU   = 4'h6;

    localparam logic [3:0] ALU_FN_MAX = 4'h3;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        logic             bad;
        logic             halt;
        logic             use_ra;
        logic             use_rb;
        logic             use_imm;
    } insn_class_t;

endpackage

// File: rtl/insn_classify.sv
module insn_classify
    import insn_dec_pkg::*;
(
    input  logic [7:0]  first_byte,
    output insn_class_t cls
);

    logic [3:0] opc;
    logic [3:0] fn;

    assign opc = first_byte[7:4];
    assign fn  = first_byte[3:0];

    always_comb begin
        cls         = '0;
        cls.len     = LEN_W'(1);
        unique case (opc)
            OPC_HALT: begin
                if (fn == 4'h0) cls.halt = 1'b1;
                else            cls.bad  = 1'b1;
            end
            OPC_NOP: begin
                if (fn != 4'h0) cls.bad = 1'b1;
            end
            OPC_RMOVE: begin
                if (fn != 4'h0) cls.bad = 1'b1;
                else begin
                    cls.len    = LEN_W'(2);
                    cls.use_ra = 1'b1;
                    cls.use_rb = 1'b1;
                end
            end
            OPC_IMOVE: begin
                if (fn != 4'h0) cls.bad = 1'b1;
                else begin
                    cls.len     = LEN_W'(6);
                    cls.use_rb  = 1'b1;
                    cls.use_imm = 1'b1;
                end
            end
            OPC_STORE, OPC_LOAD: begin
                if (fn != 4'h0) cls.bad = 1'b1;
                else begin
                    cls.len     = LEN_W'(6);
                    cls.use_ra  = 1'b1;
                    cls.use_rb  = 1'b1;
                    cls.use_imm = 1'b1;
                end
            end
            OPC_ALU: begin
                if (fn > ALU_FN_MAX) cls.bad = 1'b1;
                else begin
                    cls.len    = LEN_W'(2);
                    cls.use_ra = 1'b1;
                    cls.use_rb = 1'b1;
                end
            end
            default: cls.bad = 1'b1;
        endcase
    end

    // Immediate checks on the classification (R3, R9, R10)
    always_comb begin
        if (cls.bad)
            assert_bad_len_one_R9: assert (cls.len == LEN_W'(1) && !cls.use_imm);
        if (cls.halt)
            assert_halt_not_bad_R10: assert (!cls.bad);
    end

endmodule

// File: rtl/insn_fields.sv
module insn_fields
    import insn_dec_pkg::*;
(
    input  logic [WIN_W-1:0] win,
    input  insn_class_t      cls,
    output logic [3:0]       ra,
    output logic [3:0]       rb,
    output logic [IMM_W-1:0] imm
);

    logic [IMM_W-1:0] imm_raw;

    // Little-endian reassembly: byte IMM_FIRST+i lands in bits [8i+7:8i]
    for (genvar i = 0; i < IMM_BYTES; i++) begin : g_imm_byte
        assign imm_raw[8*i +: 8] = win[8*(IMM_FIRST+i) +: 8];
    end

    assign ra  = cls.use_ra  ? win[15:12] : REG_NONE;
    assign rb  = cls.use_rb  ? win[11:8]  : REG_NONE;
    assign imm = cls.use_imm ? imm_raw    : '0;

endmodule

// File: rtl/insn_len_decoder.sv
module insn_len_decoder
    import insn_dec_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PC_W-1:0]    pc_in,
    input  logic [WIN_W-1:0]   win_bytes,
    output logic [3:0]         op_code,
    output logic [3:0]         fn_code,
    output logic [3:0]         reg_a,
    output logic [3:0]         reg_b,
    output logic [IMM_W-1:0]   imm_val,
    output logic [LEN_W-1:0]   insn_len,
    output logic [PC_W-1:0]    next_pc,
    output logic               bad_insn,
    output logic               halt_seen
);

    insn_class_t      cls;
    logic [3:0]       ra_d;
    logic [3:0]       rb_d;
    logic [IMM_W-1:0] imm_d;
    logic [PC_W-1:0]  npc_d;

    insn_classify u_classify (
        .first_byte (win_bytes[7:0]),
        .cls        (cls)
    );

    insn_fields u_fields (
        .win (win_bytes),
        .cls (cls),
        .ra  (ra_d),
        .rb  (rb_d),
        .imm (imm_d)
    );

    assign npc_d = pc_in + PC_W'(cls.len);

    // Output register: reset-idle -> decoded on the first edge after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_code   <= '0;
            fn_code   <= '0;
            reg_a     <= REG_NONE;
            reg_b     <= REG_NONE;
            imm_val   <= '0;
            insn_len  <= '0;
            next_pc   <= '0;
            bad_insn  <= 1'b0;
            halt_seen <= 1'b0;
        end else begin
            op_code   <= win_bytes[7:4];
            fn_code   <= win_bytes[3:0];
            reg_a     <= ra_d;
            reg_b     <= rb_d;
            imm_val   <= imm_d;
            insn_len  <= cls.len;
            next_pc   <= npc_d;
            bad_insn  <= cls.bad;
            halt_seen <= cls.halt;
        end
    end

    assert_len_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (insn_len == 3'd1 || insn_len == 3'd2 || insn_len == 3'd6));

    assert_next_pc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> next_pc == $past(pc_in) + PC_W'(insn_len));

    assert_bad_regs_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_insn |-> (reg_a == REG_NONE && reg_b == REG_NONE && insn_len == 3'd1));

    assert_halt_only_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt_seen |-> (!bad_insn && op_code == 4'h0 && fn_code == 4'h0));

    assert_imm_only_long_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (imm_val != '0) |-> insn_len == 3'd6);

    assert_opcode_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> {op_code, fn_code} == $past(win_bytes[7:0]));

endmodule

// File: tb/insn_len_decoder_bench.sv
module insn_len_decoder_bench;

    localparam time TCLK = 8ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc_in = '0;
    logic [47:0] win_bytes = '0;
    logic [3:0]  op_code, fn_code, reg_a, reg_b;
    logic [31:0] imm_val, next_pc;
    logic [2:0]  insn_len;
    logic        bad_insn, halt_seen;

    int checks = 0;
    int errors = 0;

    always #(TCLK/2) clk = ~clk;

    insn_len_decoder u_insn_len_decoder (
        .clk(clk), .rst_n(rst_n), .pc_in(pc_in), .win_bytes(win_bytes),
        .op_code(op_code), .fn_code(fn_code), .reg_a(reg_a), .reg_b(reg_b),
        .imm_val(imm_val), .insn_len(insn_len), .next_pc(next_pc),
        .bad_insn(bad_insn), .halt_seen(halt_seen)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive at falling edge, let the register capture, sample just after.
    task automatic run_case(input logic [7:0] b0, input logic [7:0] b1,
                            input logic [31:0] k, input logic [31:0] pc);
        logic [3:0] hi, lo;
        logic       e_bad, e_halt;
        int         e_len;
        logic [3:0] e_ra, e_rb;
        logic [31:0] e_imm;
        @(negedge clk);
        pc_in     = pc;
        win_bytes = {k[31:24], k[23:16], k[15:8], k[7:0], b1, b0};
        hi = b0[7:4];
        lo = b0[3:0];
        e_bad = (hi > 4'd6) || (hi <= 4'd5 && lo != 0) || (hi == 4'd6 && lo > 4'd3);
        e_halt = (b0 == 8'h00);
        e_len = e_bad ? 1 : (hi <= 4'd1) ? 1 : (hi == 4'd2 || hi == 4'd6) ? 2 : 6;
        e_ra = 4'hF; e_rb = 4'hF; e_imm = 0;
        if (!e_bad && hi >= 4'd2) begin
            e_rb = b1[3:0];
            e_ra = (hi == 4'd3) ? 4'hF : b1[7:4];
            if (hi >= 4'd3 && hi <= 4'd5) e_imm = k;
        end
        @(posedge clk);
        #1;
        chk("R2", "opcode/fn", {24'd0, op_code, fn_code}, {24'd0, b0});
        chk("R3", "length", {29'd0, insn_len}, e_len);
        chk("R4", "registers", {24'd0, reg_a, reg_b}, {24'd0, e_ra, e_rb});
        chk("R5", "constant", imm_val, e_imm);
        chk("R7", "next pc", next_pc, pc + e_len);
        chk(hi == 4'd6 ? "R8" : "R9", "invalid flag", {31'd0, bad_insn}, {31'd0, e_bad});
        chk("R10", "halt flag", {31'd0, halt_seen}, {31'd0, e_halt});
        if (e_bad || hi <= 4'd1)
            chk("R6", "unused regs", {24'd0, reg_a, reg_b}, 32'h0000_00FF);
    endtask

    initial begin
        #(TCLK * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        win_bytes = 48'hABCD_EF01_2345;
        pc_in = 32'h1234_5678;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "reset regs", {24'd0, reg_a, reg_b}, 32'h0000_00FF);
        chk("R1", "reset codes", {24'd0, op_code, fn_code}, 32'd0);
        chk("R1", "reset len/pc", {29'd0, insn_len} | next_pc, 32'd0);
        chk("R1", "reset imm/flags", imm_val | {30'd0, bad_insn, halt_seen}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep every first byte with a register byte and constant
        for (int b = 0; b < 256; b++)
            run_case(8'(b), 8'h5A, 32'h8765_4321 ^ (32'(b) << 9), 32'h0000_1000 + 32'(b * 7));
        // Sweep every second byte for register-pair and immediate forms
        for (int r = 0; r < 256; r++) begin
            run_case(8'h61, 8'(r), 32'h0, 32'(r));
            run_case(8'h30, 8'(r), 32'(r) * 32'h0101_0101, 32'h2000);
        end
        // Documented example: 30 82 cd ab 00 00 (R5)
        run_case(8'h30, 8'h82, 32'h0000_abcd, 32'h100);
        // Address wrap for long and short forms (R7)
        run_case(8'h50, 8'h12, 32'hdead_beef, 32'hFFFF_FFFC);
        run_case(8'h20, 8'h34, 32'h0, 32'hFFFF_FFFF);
        run_case(8'hF0, 8'h34, 32'h1, 32'hFFFF_FFFF);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule